// File: doc/BRIEF.md
# Dual-Channel Converter Serial Command Front End

This block is the digital side of a two-channel, 16-bit voltage-output converter. A host sends 32-bit frames over a three-wire link: an active-low frame select, a serial clock and a data line. Bits are taken on the falling edge of the serial clock, most significant first. When the 32nd falling edge arrives with the frame select still low, the frame is decoded and acts on the per-channel registers.

Each channel has two stages. The staging register takes new codes. The output register drives the analog core, which reads the code as straight binary. The command field picks one of several actions: stage only, move staged to output, stage and refresh every channel, or stage and output in one step. It also covers the power-state flags, a stored clear code, an auto-follow mask, a soft reset and a stored chain-enable bit. The address field picks channel A, channel B or both.

All serial inputs are brought into the system clock domain through synchronizers. Serial clock edges are found in that domain, so the serial clock must run at no more than a quarter of the system clock rate.

Top module: `dac_serial_frontend`

## Requirements
- R1: While reset is asserted and after it is released, every output is zero: both channel codes, the power-down flags, the clear code and the chain-enable bit.
- R2: A frame is 32 bits, sent most significant bit first. Bits [31:28] are ignored, bits [27:24] hold the command, bits [23:20] hold the address, bits [19:4] hold the 16-bit code and bits [3:0] are ignored. A code reaches an output unchanged, as straight binary.
- R3: A frame acts only on the 32nd falling serial-clock edge counted while the frame select is low. A frame whose select rises earlier changes nothing. Edges seen while the select is high are not counted. Edges after the 32nd are ignored until the select rises.
- R4: Command 0000 loads the code into the staging register of each addressed channel. The outputs do not change unless the mask bit of that channel is set.
- R5: Command 0001 copies the staging register to the output of each addressed channel. The code field is ignored.
- R6: Command 0010 loads the code into the addressed staging registers. It then copies the staging register to the output on every channel, addressed or not.
- R7: Command 0011 loads the code into both the staging register and the output of each addressed channel.
- R8: Address 0000 selects channel A and address 0001 selects channel B. Address 1111 selects both channels. Any other address makes commands 0000 to 0011 change nothing.
- R9: Command 0100 loads the power-down flags from code bits [1:0], whatever the address: bit 0 for channel A and bit 1 for channel B, with 1 meaning powered down.
- R10: Command 0110 loads the mask from code bits [1:0] (bit 0 for A, bit 1 for B). A channel whose mask bit is 1 copies each command 0000 code into its output as well.
- R11: Command 0101 loads the code into the clear-code output. Command 1000 loads code bit 0 into the chain-enable output. Neither command touches the channel registers.
- R12: Command 0111 returns every register to its reset value, including the staging registers and the mask.
- R13: Commands 1001 to 1111 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_n_i | input | 1 | Frame select, active low |
| sclk_i | input | 1 | Serial clock; data is taken on its falling edge |
| sdin_i | input | 1 | Serial data, most significant bit first |
| dac_code_o | output | NUM_CH*CODE_W (32) | Output register codes; channel A in the low half |
| pd_o | output | NUM_CH (2) | Power-down flag per channel |
| clr_code_o | output | CODE_W (16) | Stored clear code |
| chain_en_o | output | 1 | Stored chain-enable bit |

## Verification
The bench runs every command against a set of addresses that includes both reserved ones, with varied codes. After each frame it compares the outputs with an arithmetic model, so a design that mixed up the staging and output stages, or that refreshed only the addressed channel on command 0010, would show a wrong code on the other channel. Directed frames cover the timing corners. A frame cut short after 20 bits must leave every output unchanged. Serial clock edges while the select is high must not be counted, or the next real frame would arrive misaligned. Four surplus edges after bit 32 must not shift the word again, which would corrupt the applied frame. Separate sequences cover the mask path, where a missing or inverted auto-follow shows up at once on the output code, and codes 0001, 8000 and C3A5 check bit order.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;

   localparam int FRAME_W  = 32;
   localparam int CMD_LSB  = 24;
   localparam int ADDR_LSB = 20;
   localparam int CODE_MSB = 19;

   typedef enum logic [3:0] {
      CMD_STAGE      = 4'h0,
      CMD_COMMIT     = 4'h1,
      CMD_STAGE_ALL  = 4'h2,
      CMD_STAGE_OUT  = 4'h3,
      CMD_POWER      = 4'h4,
      CMD_CLEAR_CODE = 4'h5,
      CMD_FOLLOW     = 4'h6,
      CMD_SOFT_RESET = 4'h7,
      CMD_CHAIN      = 4'h8
   } cmd_e;

   localparam logic [3:0] ADDR_BROADCAST = 4'hF;

   typedef struct packed {
      logic [3:0]  pad_hi;
      logic [3:0]  cmd;
      logic [3:0]  addr;
      logic [19:0] body;
   } frame_t;

endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
   parameter int         W       = 3,
   parameter int         STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("dacfe_sync: STAGES must be at least 2");
   end

   for (genvar b = 0; b < W; b++) begin : g_bit
      logic [STAGES-1:0] stage_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stage_q <= {STAGES{RST_VAL[b]}};
         end else begin
            stage_q <= {stage_q[STAGES-2:0], d_i[b]};
         end
      end
      assign q_o[b] = stage_q[STAGES-1];
   end

endmodule

// File: rtl/dacfe_shifter.sv
module dacfe_shifter #(
   parameter int FRAME_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sclk_i,
   input  logic               sync_n_i,
   input  logic               sdin_i,
   output logic               frm_vld_o,
   output logic [FRAME_W-1:0] frm_word_o
);

   localparam int CNT_W = $clog2(FRAME_W + 1);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);
   localparam logic [CNT_W-1:0] FULL     = CNT_W'(FRAME_W);

   if (FRAME_W < 2) begin : g_bad_frame
      $error("dacfe_shifter: FRAME_W too small");
   end

   logic               sclk_q;
   logic               fall;
   logic [CNT_W-1:0]   cnt_q;
   logic [FRAME_W-1:0] shift_q;
   logic [FRAME_W-1:0] shift_nxt;

   assign fall      = sclk_q & ~sclk_i;
   assign shift_nxt = {shift_q[FRAME_W-2:0], sdin_i};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q     <= 1'b1;
         cnt_q      <= '0;
         shift_q    <= '0;
         frm_vld_o  <= 1'b0;
         frm_word_o <= '0;
      end else begin
         sclk_q    <= sclk_i;
         frm_vld_o <= 1'b0;
         if (sync_n_i) begin
            cnt_q <= '0;
         end else if (fall && (cnt_q != FULL)) begin
            shift_q <= shift_nxt;
            cnt_q   <= cnt_q + 1'b1;
            if (cnt_q == LAST_BIT) begin
               frm_vld_o  <= 1'b1;
               frm_word_o <= shift_nxt;
            end
         end
      end
   end

endmodule

// File: rtl/dacfe_decoder.sv
module dacfe_decoder
   import dacfe_pkg::*;
#(
   parameter int NUM_CH = 2,
   parameter int CODE_W = 16
) (
   input  logic [FRAME_W-1:0] frm_word_i,
   input  logic               frm_vld_i,
   output logic [NUM_CH-1:0]  stage_o,
   output logic [NUM_CH-1:0]  load_now_o,
   output logic [NUM_CH-1:0]  commit_o,
   output logic               pd_ld_o,
   output logic               follow_ld_o,
   output logic               clr_ld_o,
   output logic               chain_ld_o,
   output logic               soft_rst_o,
   output logic [CODE_W-1:0]  code_o
);

   frame_t              frm;
   logic [3:0]          cmd;
   logic [3:0]          addr;
   logic [NUM_CH-1:0]   sel;
   logic                addr_ok;
   logic                unused_pad;

   assign frm    = frame_t'(frm_word_i);
   assign cmd    = frm.cmd;
   assign addr   = frm.addr;
   assign code_o = frm_word_i[CODE_MSB -: CODE_W];

   assign unused_pad = ^{frm.pad_hi, frm_word_i[CODE_MSB-CODE_W:0]};

   always_comb begin
      for (int c = 0; c < NUM_CH; c++) begin
         sel[c] = (addr == 4'(c)) || (addr == ADDR_BROADCAST);
      end
   end

   assign addr_ok = |sel;

   always_comb begin
      stage_o     = '0;
      load_now_o  = '0;
      commit_o    = '0;
      pd_ld_o     = 1'b0;
      follow_ld_o = 1'b0;
      clr_ld_o    = 1'b0;
      chain_ld_o  = 1'b0;
      soft_rst_o  = 1'b0;
      if (frm_vld_i) begin
         case (cmd)
            CMD_STAGE: begin
               stage_o = sel;
            end
            CMD_COMMIT: begin
               commit_o = sel;
            end
            CMD_STAGE_ALL: begin
               if (addr_ok) begin
                  stage_o    = sel;
                  load_now_o = sel;
                  commit_o   = ~sel;
               end
            end
            CMD_STAGE_OUT: begin
               stage_o    = sel;
               load_now_o = sel;
            end
            CMD_POWER:      pd_ld_o     = 1'b1;
            CMD_CLEAR_CODE: clr_ld_o    = 1'b1;
            CMD_FOLLOW:     follow_ld_o = 1'b1;
            CMD_SOFT_RESET: soft_rst_o  = 1'b1;
            CMD_CHAIN:      chain_ld_o  = 1'b1;
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/dacfe_channel.sv
module dacfe_channel #(
   parameter int CODE_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst_i,
   input  logic              stage_i,
   input  logic              load_now_i,
   input  logic              commit_i,
   input  logic              pd_ld_i,
   input  logic              pd_val_i,
   input  logic              follow_ld_i,
   input  logic              follow_val_i,
   input  logic [CODE_W-1:0] code_i,
   output logic [CODE_W-1:0] dac_o,
   output logic              pd_o
);

   logic [CODE_W-1:0] stage_q;
   logic [CODE_W-1:0] dac_q;
   logic              pd_q;
   logic              follow_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q  <= '0;
         dac_q    <= '0;
         pd_q     <= 1'b0;
         follow_q <= 1'b0;
      end else if (soft_rst_i) begin
         stage_q  <= '0;
         dac_q    <= '0;
         pd_q     <= 1'b0;
         follow_q <= 1'b0;
      end else begin
         if (stage_i) begin
            stage_q <= code_i;
            if (load_now_i || follow_q) begin
               dac_q <= code_i;
            end
         end else if (commit_i) begin
            dac_q <= stage_q;
         end
         if (pd_ld_i) begin
            pd_q <= pd_val_i;
         end
         if (follow_ld_i) begin
            follow_q <= follow_val_i;
         end
      end
   end

   assign dac_o = dac_q;
   assign pd_o  = pd_q;

endmodule

// File: rtl/dac_serial_frontend.sv
module dac_serial_frontend
   import dacfe_pkg::*;
#(
   parameter int NUM_CH      = 2,
   parameter int CODE_W      = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     sync_n_i,
   input  logic                     sclk_i,
   input  logic                     sdin_i,
   output logic [NUM_CH*CODE_W-1:0] dac_code_o,
   output logic [NUM_CH-1:0]        pd_o,
   output logic [CODE_W-1:0]        clr_code_o,
   output logic                     chain_en_o
);

   if (CODE_W < 12 || CODE_W > 16) begin : g_bad_code_w
      $error("dac_serial_frontend: CODE_W must lie in 12..16");
   end
   if (NUM_CH < 1 || NUM_CH > 8) begin : g_bad_num_ch
      $error("dac_serial_frontend: NUM_CH must lie in 1..8");
   end

   logic [2:0]          pins_s;
   logic                sync_n_s;
   logic                sclk_s;
   logic                sdin_s;
   logic                frm_vld;
   logic [FRAME_W-1:0]  frm_word;
   logic [NUM_CH-1:0]   stage;
   logic [NUM_CH-1:0]   load_now;
   logic [NUM_CH-1:0]   commit;
   logic                pd_ld;
   logic                follow_ld;
   logic                clr_ld;
   logic                chain_ld;
   logic                soft_rst;
   logic [CODE_W-1:0]   code;
   logic [CODE_W-1:0]   clr_q;
   logic                chain_q;

   dacfe_sync #(
      .W       (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b110)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({sync_n_i, sclk_i, sdin_i}),
      .q_o   (pins_s)
   );

   assign sync_n_s = pins_s[2];
   assign sclk_s   = pins_s[1];
   assign sdin_s   = pins_s[0];

   dacfe_shifter #(
      .FRAME_W (FRAME_W)
   ) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .sclk_i     (sclk_s),
      .sync_n_i   (sync_n_s),
      .sdin_i     (sdin_s),
      .frm_vld_o  (frm_vld),
      .frm_word_o (frm_word)
   );

   dacfe_decoder #(
      .NUM_CH (NUM_CH),
      .CODE_W (CODE_W)
   ) u_dec (
      .frm_word_i  (frm_word),
      .frm_vld_i   (frm_vld),
      .stage_o     (stage),
      .load_now_o  (load_now),
      .commit_o    (commit),
      .pd_ld_o     (pd_ld),
      .follow_ld_o (follow_ld),
      .clr_ld_o    (clr_ld),
      .chain_ld_o  (chain_ld),
      .soft_rst_o  (soft_rst),
      .code_o      (code)
   );

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      dacfe_channel #(
         .CODE_W (CODE_W)
      ) u_ch (
         .clk          (clk),
         .rst_n        (rst_n),
         .soft_rst_i   (soft_rst),
         .stage_i      (stage[g]),
         .load_now_i   (load_now[g]),
         .commit_i     (commit[g]),
         .pd_ld_i      (pd_ld),
         .pd_val_i     (code[g]),
         .follow_ld_i  (follow_ld),
         .follow_val_i (code[g]),
         .code_i       (code),
         .dac_o        (dac_code_o[g*CODE_W +: CODE_W]),
         .pd_o         (pd_o[g])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clr_q   <= '0;
         chain_q <= 1'b0;
      end else if (soft_rst) begin
         clr_q   <= '0;
         chain_q <= 1'b0;
      end else begin
         if (clr_ld) begin
            clr_q <= code;
         end
         if (chain_ld) begin
            chain_q <= code[0];
         end
      end
   end

   assign clr_code_o = clr_q;
   assign chain_en_o = chain_q;

endmodule

// File: rtl/dacfe_checker.sv
module dacfe_checker #(
   parameter int NUM_CH = 2,
   parameter int CODE_W = 16
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     sync_n_s,
   input logic                     frm_vld,
   input logic [3:0]               frm_cmd,
   input logic [NUM_CH*CODE_W-1:0] dac_code,
   input logic [NUM_CH-1:0]        pd,
   input logic [CODE_W-1:0]        clr_code,
   input logic                     chain_en
);

   AST_RESET_CLEAR: assert property (@(posedge clk)
      !rst_n |=> (dac_code == '0 && pd == '0 && clr_code == '0 && !chain_en)); // R1

   AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      frm_vld |=> !frm_vld); // R3

   AST_FRAME_IN_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      frm_vld |-> $past(!sync_n_s)); // R3

   AST_QUIET_WITHOUT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      !frm_vld |=> ($stable(dac_code) && $stable(pd) && $stable(clr_code) && $stable(chain_en))); // R3

   AST_RESERVED_CMD_INERT: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_vld && frm_cmd >= 4'h9) |=> ($stable(dac_code) && $stable(pd) && $stable(clr_code) && $stable(chain_en))); // R13

   AST_PD_ONLY_BY_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_vld && frm_cmd != 4'h4 && frm_cmd != 4'h7) |=> $stable(pd)); // R9

endmodule

bind dac_serial_frontend dacfe_checker #(
   .NUM_CH (NUM_CH),
   .CODE_W (CODE_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .sync_n_s (sync_n_s),
   .frm_vld  (frm_vld),
   .frm_cmd  (frm_word[27:24]),
   .dac_code (dac_code_o),
   .pd       (pd_o),
   .clr_code (clr_code_o),
   .chain_en (chain_en_o)
);

// File: tb/dac_serial_frontend_tb_top.sv
module dac_serial_frontend_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sync_n = 1'b1;
   logic        sclk = 1'b1;
   logic        sdin = 1'b0;
   logic [31:0] dac_code;
   logic [1:0]  pd;
   logic [15:0] clr_code;
   logic        chain_en;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   logic [15:0] stage_m [2];
   logic [15:0] dac_m [2];
   logic [1:0]  pd_m;
   logic [1:0]  follow_m;
   logic [15:0] clr_m;
   logic        chain_m;

   always #10 clk = ~clk;

   dac_serial_frontend dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .sync_n_i   (sync_n),
      .sclk_i     (sclk),
      .sdin_i     (sdin),
      .dac_code_o (dac_code),
      .pd_o       (pd),
      .clr_code_o (clr_code),
      .chain_en_o (chain_en)
   );

   function automatic logic [31:0] mk(input logic [3:0] c, input logic [3:0] a, input logic [15:0] d);
      return {4'hA, c, a, d, 4'h5};
   endfunction

   task automatic model_reset();
      for (int ch = 0; ch < 2; ch++) begin
         stage_m[ch] = '0;
         dac_m[ch]   = '0;
      end
      pd_m = '0; follow_m = '0; clr_m = '0; chain_m = 1'b0;
   endtask

   task automatic model(input logic [3:0] c, input logic [3:0] a, input logic [15:0] d);
      logic [1:0] s;
      s = (a == 4'h0) ? 2'b01 : (a == 4'h1) ? 2'b10 : (a == 4'hF) ? 2'b11 : 2'b00;
      case (c)
         4'h0: for (int ch = 0; ch < 2; ch++) if (s[ch]) begin
                  stage_m[ch] = d;
                  if (follow_m[ch]) dac_m[ch] = d;
               end
         4'h1: for (int ch = 0; ch < 2; ch++) if (s[ch]) dac_m[ch] = stage_m[ch];
         4'h2: if (s != 2'b00) begin
                  for (int ch = 0; ch < 2; ch++) if (s[ch]) stage_m[ch] = d;
                  for (int ch = 0; ch < 2; ch++) dac_m[ch] = stage_m[ch];
               end
         4'h3: for (int ch = 0; ch < 2; ch++) if (s[ch]) begin
                  stage_m[ch] = d;
                  dac_m[ch]   = d;
               end
         4'h4: pd_m = d[1:0];
         4'h5: clr_m = d;
         4'h6: follow_m = d[1:0];
         4'h7: model_reset();
         4'h8: chain_m = d[0];
         default: ;
      endcase
   endtask

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic check_all(input string req);
      chk(req, "dac_a", {16'h0, dac_code[15:0]}, {16'h0, dac_m[0]});
      chk(req, "dac_b", {16'h0, dac_code[31:16]}, {16'h0, dac_m[1]});
      chk(req, "pd", {30'h0, pd}, {30'h0, pd_m});
      chk(req, "clr", {16'h0, clr_code}, {16'h0, clr_m});
      chk(req, "chain", {31'h0, chain_en}, {31'h0, chain_m});
   endtask

   task automatic send(input logic [31:0] w, input int nbits);
      @(negedge clk);
      sclk = 1'b1;
      sync_n = 1'b0;
      repeat (4) @(negedge clk);
      for (int i = 0; i < nbits; i++) begin
         sdin = (i < 32) ? w[31-i] : 1'b1;
         repeat (4) @(negedge clk);
         sclk = 1'b0;
         repeat (4) @(negedge clk);
         sclk = 1'b1;
      end
      repeat (4) @(negedge clk);
      sync_n = 1'b1;
      repeat (10) @(negedge clk);
   endtask

   task automatic frame(input logic [3:0] c, input logic [3:0] a, input logic [15:0] d);
      send(mk(c, a, d), 32);
      model(c, a, d);
   endtask

   function automatic string tag_of(input logic [3:0] c, input logic [3:0] a);
      if (c <= 4'h3 && !(a == 4'h0 || a == 4'h1 || a == 4'hF)) return "R8";
      case (c)
         4'h0: return "R4";
         4'h1: return "R5";
         4'h2: return "R6";
         4'h3: return "R7";
         4'h4: return "R9";
         4'h5: return "R11";
         4'h6: return "R10";
         4'h7: return "R12";
         4'h8: return "R11";
         default: return "R13";
      endcase
   endfunction

   initial begin
      logic [3:0] addrs [5];
      addrs[0] = 4'h0; addrs[1] = 4'h1; addrs[2] = 4'hF; addrs[3] = 4'h2; addrs[4] = 4'h3;
      model_reset();
      repeat (5) @(negedge clk);
      check_all("R1");
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check_all("R1");

      // R2 / R7: bit order and straight-binary codes
      frame(4'h3, 4'h0, 16'hC3A5);
      check_all("R2");
      frame(4'h3, 4'h1, 16'h0001);
      check_all("R2");
      frame(4'h3, 4'h0, 16'h8000);
      check_all("R7");

      // R3: truncated frame is discarded
      send(mk(4'h3, 4'h0, 16'h1111), 20);
      check_all("R3");
      // R3: edges while select is high are not counted
      for (int i = 0; i < 40; i++) begin
         sdin = i[0];
         repeat (4) @(negedge clk);
         sclk = 1'b0;
         repeat (4) @(negedge clk);
         sclk = 1'b1;
      end
      repeat (6) @(negedge clk);
      check_all("R3");
      frame(4'h3, 4'h1, 16'h2468);
      check_all("R3");
      // R3: surplus edges after bit 32 are ignored
      send(mk(4'h3, 4'h1, 16'h2222), 36);
      model(4'h3, 4'h1, 16'h2222);
      check_all("R3");

      // R8: reserved address
      frame(4'h3, 4'h2, 16'h7777);
      check_all("R8");

      // R10: follow mask on channel A only
      frame(4'h6, 4'h0, 16'h0001);
      frame(4'h0, 4'h0, 16'h4444);
      check_all("R10");
      frame(4'h0, 4'h1, 16'h5555);
      check_all("R10");
      frame(4'h1, 4'h1, 16'h0000);
      check_all("R5");

      // R12: soft reset
      frame(4'h4, 4'h0, 16'h0003);
      frame(4'h5, 4'h0, 16'hBEEF);
      frame(4'h8, 4'h0, 16'h0001);
      check_all("R11");
      frame(4'h7, 4'h0, 16'h0000);
      check_all("R12");

      // sweep over commands and addresses
      for (int pass = 0; pass < 2; pass++) begin
         for (int ai = 0; ai < 5; ai++) begin
            for (int k = 0; k < 16; k++) begin
               logic [3:0]  c;
               logic [15:0] d;
               c = 4'((k * 7) % 16);
               d = 16'((k * 16'h2F1B + ai * 16'h1357 + pass * 16'h0A5C) ^ 16'h8001);
               frame(c, addrs[ai], d);
               check_all(tag_of(c, addrs[ai]));
            end
         end
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL R3 watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule